// File: doc/BRIEF.md
# Coprocessor busy-error interface controller

This block sits between a host CPU and a numeric coprocessor on a PC-style I/O bus. It forwards the coprocessor's active-low busy signal to the CPU. If the coprocessor signals an unmasked error while it is busy, the block captures that event in a sticky flag. The flag holds the CPU busy line low and raises an interrupt request, so the CPU stalls on its next coprocessor instruction and software can service the error.

Software releases the flag with an I/O write to one of two ports. A write to the first port only releases the flag. A write to the second port releases it and also holds the coprocessor in reset for a fixed number of clocks.

The coprocessor's error and busy inputs are asynchronous. Each goes through a two-flop synchronizer before any decision uses it. The I/O write strobe and address are sampled on the rising clock edge. All control pins are plain levels, and the block has no streaming interface.

Top module: `copro_busy_guard`

## Requirements
- R1: While no error is held, `cpu_busy_n` equals `copro_busy_n` as it was sampled two rising edges earlier, through the two-flop synchronizer.
- R2: The sticky error flag is set at a rising edge where the synchronized `copro_err_n` and the synchronized `copro_busy_n` are both low. From then on, `cpu_busy_n` stays low, even after `copro_busy_n` returns high.
- R3: A synchronized error with coprocessor busy not asserted in that same clock does not set the flag.
- R4: A qualifying write to address 10'h0F0 clears the flag at that edge and leaves `copro_rst_n` high.
- R5: A qualifying write to address 10'h0F1 clears the flag. It also drives `copro_rst_n` low for exactly 4 clock cycles, starting right after the qualifying edge.
- R6: The address compare uses all 10 bits. Writes to other addresses, including 10'h1F0 and 10'h2F1, have no effect.
- R7: A write qualifies only at the first rising edge where `io_wr_n` is sampled low. Holding the strobe low longer gives no further clear and no further reset pulse.
- R8: `irq_err` is high exactly while the sticky flag is set.
- R9: When a set condition and a clear occur at the same edge, the flag stays set.
- R10: `rst` clears the flag asynchronously and drives `copro_rst_n` low while it is high. The synchronizers reset to the deasserted level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, active high, asynchronous |
| copro_err_n | input | 1 | Coprocessor error summary, active low, asynchronous |
| copro_busy_n | input | 1 | Coprocessor busy, active low, asynchronous |
| io_wr_n | input | 1 | I/O write strobe, active low |
| io_addr | input | 10 | I/O address |
| cpu_busy_n | output | 1 | Busy to the CPU, active low |
| irq_err | output | 1 | Math error interrupt request, active high |
| copro_rst_n | output | 1 | Coprocessor reset, active low |

## Verification
The hardest state to reach is a set condition and a clear arriving at the same edge. For that, both synchronized inputs must be low in exactly the clock where a new write strobe to 10'h0F0 is first sampled. A directed sequence holds error and busy low over several cycles and opens the strobe in their middle. Long strobes to the reset port come right after a latched error, so the one-shot decode and the pulse length are seen against a set flag. Random traffic then mixes short error glitches, aliased addresses and a mid-run reset against a cycle model in the bench.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int unsigned IO_ADDR_W     = 10;
  localparam logic [9:0]  PORT_CLR_ONLY = 10'h0F0;
  localparam logic [9:0]  PORT_CLR_RST  = 10'h0F1;

  // synchronized coprocessor status, active-low levels as on the pins
  typedef struct packed {
    logic err_n;
    logic busy_n;
  } copro_stat_t;
endpackage

// File: rtl/cbg_sync.sv
module cbg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        chain[s] <= '1;
      end else if (s == 0) begin
        chain[s] <= d;
      end else begin
        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cbg_port_decode.sv
module cbg_port_decode #(
  parameter int unsigned      ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] CLR_PORT = 10'h0F0,
  parameter logic [ADDR_W-1:0] RST_PORT = 10'h0F1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr_n,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              clr_hit,
  output logic              rst_hit
);
  logic wr_seen;
  logic first_wr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) wr_seen <= 1'b0;
    else     wr_seen <= ~io_wr_n;
  end

  assign first_wr = ~io_wr_n & ~wr_seen;
  assign rst_hit  = first_wr & (io_addr == RST_PORT);
  assign clr_hit  = first_wr & ((io_addr == CLR_PORT) | (io_addr == RST_PORT));

  AST_ONE_HIT_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> !clr_hit); // R7
endmodule

// File: rtl/cbg_rst_stretch.sv
module cbg_rst_stretch #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse_n
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                remain <= '0;
    else if (start)         remain <= LOAD;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign pulse_n = ~rst & (remain == '0);

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
    start |=> !pulse_n); // R5
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    remain <= LOAD); // R5
endmodule

// File: rtl/copro_busy_guard.sv
module copro_busy_guard
  import cbg_pkg::*;
#(
  parameter int unsigned          ADDR_W      = IO_ADDR_W,
  parameter logic [ADDR_W-1:0]    CLR_PORT    = PORT_CLR_ONLY,
  parameter logic [ADDR_W-1:0]    RST_PORT    = PORT_CLR_RST,
  parameter int unsigned          RST_CYCLES  = 4,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              copro_err_n,
  input  logic              copro_busy_n,
  input  logic              io_wr_n,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              cpu_busy_n,
  output logic              irq_err,
  output logic              copro_rst_n
);
  localparam int unsigned STAT_W = $bits(copro_stat_t);

  copro_stat_t raw_stat, sync_stat;
  logic        err_act, busy_act, set_cond;
  logic        clr_hit, rst_hit;
  logic        held;

  assign raw_stat.err_n  = copro_err_n;
  assign raw_stat.busy_n = copro_busy_n;

  cbg_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_stat),
    .q   (sync_stat)
  );

  cbg_port_decode #(.ADDR_W(ADDR_W), .CLR_PORT(CLR_PORT), .RST_PORT(RST_PORT)) i_dec (
    .clk     (clk),
    .rst     (rst),
    .io_wr_n (io_wr_n),
    .io_addr (io_addr),
    .clr_hit (clr_hit),
    .rst_hit (rst_hit)
  );

  cbg_rst_stretch #(.CYCLES(RST_CYCLES)) i_stretch (
    .clk     (clk),
    .rst     (rst),
    .start   (rst_hit),
    .pulse_n (copro_rst_n)
  );

  assign err_act  = ~sync_stat.err_n;
  assign busy_act = ~sync_stat.busy_n;
  assign set_cond = err_act & busy_act;

  // set wins over clear so a persisting error is never dropped
  always_ff @(posedge clk or posedge rst) begin
    if (rst)           held <= 1'b0;
    else if (set_cond) held <= 1'b1;
    else if (clr_hit)  held <= 1'b0;
  end

  assign cpu_busy_n = held ? 1'b0 : sync_stat.busy_n;
  assign irq_err    = held;

  AST_LATCH_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
    set_cond |=> (!cpu_busy_n && irq_err)); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_err) |-> $past(set_cond)); // R3
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !set_cond) |=> !irq_err); // R4
  AST_CLR_PORT_NO_RESET: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !rst_hit && copro_rst_n) |=> copro_rst_n); // R4
endmodule

// File: tb/test_copro_busy_guard.sv
module test_copro_busy_guard;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       copro_err_n = 1'b1;
  logic       copro_busy_n = 1'b1;
  logic       io_wr_n = 1'b1;
  logic [9:0] io_addr = '0;
  logic       cpu_busy_n, irq_err, copro_rst_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model state
  logic m_e1, m_e2, m_b1, m_b2, m_held, m_wr;
  int   m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  copro_busy_guard i_copro_busy_guard (
    .clk(clk), .rst(rst), .copro_err_n(copro_err_n), .copro_busy_n(copro_busy_n),
    .io_wr_n(io_wr_n), .io_addr(io_addr),
    .cpu_busy_n(cpu_busy_n), .irq_err(irq_err), .copro_rst_n(copro_rst_n)
  );

  function automatic logic exp_busy_n();
    return m_held ? 1'b0 : m_b2;
  endfunction

  function automatic logic exp_rst_n();
    return !rst && (m_cnt == 0);
  endfunction

  task automatic model_reset();
    m_e1 = 1; m_e2 = 1; m_b1 = 1; m_b2 = 1; m_held = 0; m_wr = 0; m_cnt = 0;
  endtask

  task automatic model_edge();
    logic setc, first, clr, rp;
    setc  = !m_e2 && !m_b2;
    first = !io_wr_n && !m_wr;
    clr   = first && (io_addr == 10'h0F0 || io_addr == 10'h0F1);
    rp    = first && (io_addr == 10'h0F1);
    if (setc)     m_held = 1;
    else if (clr) m_held = 0;
    if (rp)             m_cnt = 4;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_wr = !io_wr_n;
    m_e2 = m_e1; m_b2 = m_b1;
    m_e1 = copro_err_n; m_b1 = copro_busy_n;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "cpu_busy_n", cpu_busy_n, exp_busy_n());
    chk(req, "irq_err", irq_err, m_held);
    chk(req, "copro_rst_n", copro_rst_n, exp_rst_n());
  endtask

  task automatic step(string req, logic e, logic b, logic w, logic [9:0] a);
    @(negedge clk);
    copro_err_n = e; copro_busy_n = b; io_wr_n = w; io_addr = a;
    @(posedge clk);
    model_edge();
    #1;
    compare_all(req);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 1, 1, 1, 10'h000);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    model_reset();
    #(CLK_PERIOD*2 + 1);
    compare_all("R10 in reset");
    @(negedge clk); rst = 0;
    idle("R10 after reset", 3);

    // R1: busy pass-through with two clocks of latency
    step("R1", 1, 0, 1, 0);
    step("R1", 1, 0, 1, 0);
    step("R1", 1, 0, 1, 0);
    step("R1", 1, 1, 1, 0);
    idle("R1", 3);

    // R3: error without busy
    for (int i = 0; i < 4; i++) step("R3", 0, 1, 1, 0);
    idle("R3", 3);

    // R2, R8: one-clock coincident error and busy, then busy released
    step("R2", 0, 0, 1, 0);
    idle("R2 R8 hold", 6);

    // R6: aliased addresses leave the flag alone
    step("R6", 1, 1, 0, 10'h1F0);
    idle("R6", 2);
    step("R6", 1, 1, 0, 10'h2F1);
    idle("R6", 2);
    step("R6", 1, 1, 0, 10'h0F2);
    idle("R6", 3);

    // R4, R7: long strobe to clear-only port
    for (int i = 0; i < 5; i++) step("R4 R7", 1, 1, 0, 10'h0F0);
    idle("R4", 3);

    // R5, R7: relatch, then long strobe to reset port
    step("R2", 0, 0, 1, 0);
    idle("R2", 3);
    for (int i = 0; i < 7; i++) step("R5 R7", 1, 1, 0, 10'h0F1);
    idle("R5", 6);
    // short strobe to reset port, pulse width independent of strobe
    step("R5", 1, 1, 0, 10'h0F1);
    idle("R5", 7);

    // R9: set condition coincides with first strobe edge
    step("R9", 0, 0, 1, 0);
    step("R9", 0, 0, 1, 0);
    step("R9", 0, 0, 0, 10'h0F0);
    step("R9", 0, 0, 0, 10'h0F0);
    step("R9", 1, 1, 1, 0);
    idle("R9", 4);
    step("R4", 1, 1, 0, 10'h0F0);
    idle("R4", 3);

    // R10: reset mid-run with flag set
    step("R2", 0, 0, 1, 0);
    idle("R2", 3);
    @(negedge clk); #1 rst = 1; model_reset(); #1;
    compare_all("R10 async");
    @(negedge clk); rst = 0;
    idle("R10", 3);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic e, b, w;
      logic [9:0] a;
      int unsigned r;
      r = $urandom % 100;
      e = (r < 12) ? 1'b0 : 1'b1;
      b = ($urandom % 3 == 0) ? ~copro_busy_n : copro_busy_n;
      w = ($urandom % 4 == 0) ? ~io_wr_n : io_wr_n;
      case ($urandom % 6)
        0: a = 10'h0F0;
        1: a = 10'h0F1;
        2: a = 10'h1F0;
        3: a = 10'h3F1;
        default: a = io_addr;
      endcase
      step("R1 R2 R3 R4 R5 R6 R7 R8 R9", e, b, w, a);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule